// File: doc/BRIEF.md
# System Control Space Address Router

This block sits between a core's bus port and the small set of register blocks that live in the 1 MB system control region at 0xE000_0000 to 0xE00F_FFFF. Each request carries an address, a direction, a size, write data, and two attributes: privileged and secure. The router picks exactly one destination. The destination is the interrupt controller and system register port, the secure or the non-secure timer, an optional reliability register block, or a built-in default responder. The default responder reads as zero and drops writes for privileged callers, and raises a bus fault for unprivileged ones.

Regions may overlap, and the region with the higher priority wins. The timer registers sit inside the 4 KB system register window and take precedence there. When the security extension is built in, a second 4 KB window lets secure software reach the non-secure copy of the system registers. The router forwards such an access as if it came from non-secure code.

The decode result is held for one register stage. In the cycle after a request, the router drives a one-hot select toward the chosen slave, together with the forwarded offset, data and attributes. In that same cycle it returns the response, with read data taken from that slave's read bus.

Top module: `sys_space_router`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `resp_valid`, `resp_fault` and all four slave selects are low, even if `req_valid` is high during reset.
- R2: A request accepted on a rising edge with `req_valid` high produces `resp_valid` high for exactly the following cycle. A cycle without a request produces no response one cycle later.
- R3: Addresses 0xE000_E000 to 0xE000_EFFF outside the timer sub-range select the system register port (`sel_sysreg`). `fwd_offset` equals address bits [11:0], and a read returns `rd_sysreg`.
- R4: Inside the system register window, offsets 0x010 to 0x0EF (inclusive) belong to the timer, which has the higher priority. Offset 0x00C and offset 0x0F0 stay with the system register port.
- R5: A timer access with `req_secure`=1 selects `sel_tmr_s` and returns `rd_tmr_s`. With `req_secure`=0 it selects `sel_tmr_ns` and returns `rd_tmr_ns`. `fwd_secure` follows the request's secure attribute.
- R6: With HAS_SEC=1, a secure access to 0xE002_E000 to 0xE002_EFFF is routed as if it targeted 0xE000_E000 plus the same offset, with `fwd_secure`=0. An alias timer access therefore reaches the non-secure timer.
- R7: A non-secure access to the alias window goes to the default responder. It reads as zero with no fault when privileged, and faults when unprivileged.
- R8: A privileged access to an address no slave claims asserts no select and no fault, and returns read data 0. A write there therefore reaches no slave.
- R9: An unprivileged access to an unclaimed address returns `resp_fault`=1 with read data 0 and no select.
- R10: With HAS_REL=1, addresses 0xE000_5000 to 0xE000_5FFF select `sel_rel` and return `rd_rel`.
- R11: With HAS_SEC=0, alias window addresses go to the default responder. With HAS_REL=0, the 0xE000_5xxx page goes to the default responder.
- R12: All four `req_size` codes (0=1, 1=2, 2=4, 3=8 bytes) are accepted without fault by the default responder for privileged callers, and are forwarded unchanged on `fwd_size`.
- R13: On a write, `fwd_write`=1 and `fwd_wdata` equals the request data, and `resp_rdata` is 0.
- R14: Addresses outside 0xE000_0000 to 0xE00F_FFFF go to the default responder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code, 0..3 = 1,2,4,8 bytes |
| req_wdata | input | 32 | Write data |
| req_priv | input | 1 | Privileged attribute |
| req_secure | input | 1 | Secure attribute |
| sel_sysreg | output | 1 | Select of the system register port |
| sel_tmr_s | output | 1 | Select of the secure timer |
| sel_tmr_ns | output | 1 | Select of the non-secure timer |
| sel_rel | output | 1 | Select of the reliability block |
| fwd_offset | output | 12 | Offset inside the selected 4 KB page |
| fwd_write | output | 1 | Forwarded direction |
| fwd_wdata | output | 32 | Forwarded write data |
| fwd_size | output | 2 | Forwarded size code |
| fwd_secure | output | 1 | Forwarded (possibly rewritten) secure attribute |
| rd_sysreg | input | 32 | Read data from system register port |
| rd_tmr_s | input | 32 | Read data from secure timer |
| rd_tmr_ns | input | 32 | Read data from non-secure timer |
| rd_rel | input | 32 | Read data from reliability block |
| resp_valid | output | 1 | Response present |
| resp_rdata | output | 32 | Response read data |
| resp_fault | output | 1 | Bus fault response |

## Verification
A wrong decode in the registered stage shows at the ports exactly one cycle after the offending request. It appears as a select on the wrong slave, read data from the wrong stub, a missing or spurious fault, or a secure attribute that was not cleared for an alias access. The bench therefore compares every response against a model in the cycle it appears. The stubs return data tagged with the slave identity and the offset, so a misrouted or misaligned access cannot match by accident. Boundary offsets of the timer sub-range and both attribute polarities of the alias window are exercised, and a second instance built without the optional windows confirms the fall-through paths.

// File: rtl/ppb_pkg.sv
// Package: shared target encoding and fixed address constants of the
// system control space router. Assumes 32-bit addresses, 4 KB pages.
package ppb_pkg;
    typedef enum logic [2:0] {
        TGT_RAZ    = 3'd0,
        TGT_FAULT  = 3'd1,
        TGT_SYS    = 3'd2,
        TGT_TMR_S  = 3'd3,
        TGT_TMR_NS = 3'd4,
        TGT_REL    = 3'd5
    } ppb_tgt_e;

    localparam int          PAGE_W     = 12;
    localparam logic [11:0] SPACE_TAG  = 12'hE00;
    localparam logic [7:0]  PAGE_SCS   = 8'h0E;
    localparam logic [7:0]  PAGE_ALIAS = 8'h2E;
    localparam logic [7:0]  PAGE_REL   = 8'h05;
    localparam logic [11:0] TMR_LO     = 12'h010;
    localparam logic [11:0] TMR_HI     = 12'h0EF;
endpackage

// File: rtl/ppb_win_decode.sv
// Module: resolves one 4 KB control window. The timer range (priority 1)
// overrides the system register region (priority 0). Assumes the caller
// has already decided that the window is hit and which security applies.
module ppb_win_decode
    import ppb_pkg::*;
#(
    parameter int OFF_W = PAGE_W
) (
    input  logic [OFF_W-1:0] off,
    input  logic             secure,
    output ppb_tgt_e         tgt
);
    logic tmr_hit;

    // Timer sub-range membership, bounds inclusive.
    always_comb tmr_hit = (off >= TMR_LO) && (off <= TMR_HI);

    // Higher-priority timer region wins over the enclosing register region.
    always_comb begin
        if (tmr_hit) tgt = secure ? TGT_TMR_S : TGT_TMR_NS;
        else         tgt = TGT_SYS;
    end
endmodule

// File: rtl/ppb_decode.sv
// Module: combinational decode of a full request into a target and the
// effective secure attribute. Optional alias and reliability windows are
// chosen by parameters; absent windows fall to the default responder.
module ppb_decode
    import ppb_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter bit HAS_SEC = 1'b1,
    parameter bit HAS_REL = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              priv,
    input  logic              secure,
    output ppb_tgt_e          tgt,
    output logic              eff_secure
);
    localparam int TAG_LSB  = ADDR_W - 12;
    localparam int PAGE_LSB = PAGE_W;

    logic       in_space;
    logic [7:0] page;
    logic       scs_hit;
    logic       alias_hit;
    logic       rel_hit;
    ppb_tgt_e   main_tgt;
    ppb_tgt_e   alias_tgt;

    // Split the address into space tag and page number.
    always_comb begin
        in_space = (addr[ADDR_W-1:TAG_LSB] == SPACE_TAG);
        page     = addr[PAGE_LSB+7:PAGE_LSB];
        scs_hit  = in_space && (page == PAGE_SCS);
    end

    ppb_win_decode #(.OFF_W(PAGE_W)) u_main (
        .off    (addr[PAGE_W-1:0]),
        .secure (secure),
        .tgt    (main_tgt)
    );

    generate
        if (HAS_SEC) begin : g_alias
            // Alias window always decodes as the non-secure view.
            ppb_win_decode #(.OFF_W(PAGE_W)) u_alias (
                .off    (addr[PAGE_W-1:0]),
                .secure (1'b0),
                .tgt    (alias_tgt)
            );
            assign alias_hit = in_space && (page == PAGE_ALIAS);
        end else begin : g_no_alias
            assign alias_tgt = TGT_RAZ;
            assign alias_hit = 1'b0;
        end

        if (HAS_REL) begin : g_rel
            assign rel_hit = in_space && (page == PAGE_REL);
        end else begin : g_no_rel
            assign rel_hit = 1'b0;
        end
    endgenerate

    // Priority pick: default responder first, then any claiming region.
    always_comb begin
        tgt        = priv ? TGT_RAZ : TGT_FAULT;
        eff_secure = secure;
        if (scs_hit) begin
            tgt = main_tgt;
        end else if (alias_hit && secure) begin
            tgt        = alias_tgt;
            eff_secure = 1'b0;
        end else if (rel_hit) begin
            tgt = TGT_REL;
        end
    end
endmodule

// File: rtl/ppb_resp_stage.sv
// Module: the single register stage. Holds the decoded target and the
// forwarded fields, drives one-hot slave selects and muxes the response.
// Assumes slaves return read data combinationally in the select cycle.
module ppb_resp_stage
    import ppb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OFF_W  = PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  ppb_tgt_e          in_tgt,
    input  logic [OFF_W-1:0]  in_off,
    input  logic              in_write,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic [1:0]        in_size,
    input  logic              in_secure,
    input  logic [DATA_W-1:0] rd_sysreg,
    input  logic [DATA_W-1:0] rd_tmr_s,
    input  logic [DATA_W-1:0] rd_tmr_ns,
    input  logic [DATA_W-1:0] rd_rel,
    output logic              sel_sysreg,
    output logic              sel_tmr_s,
    output logic              sel_tmr_ns,
    output logic              sel_rel,
    output logic [OFF_W-1:0]  fwd_offset,
    output logic              fwd_write,
    output logic [DATA_W-1:0] fwd_wdata,
    output logic [1:0]        fwd_size,
    output logic              fwd_secure,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              resp_fault
);
    logic     st_valid;
    ppb_tgt_e st_tgt;
    logic [DATA_W-1:0] slave_rd;

    // Capture the decode result and forwarded fields once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_valid   <= 1'b0;
            st_tgt     <= TGT_RAZ;
            fwd_offset <= '0;
            fwd_write  <= 1'b0;
            fwd_wdata  <= '0;
            fwd_size   <= '0;
            fwd_secure <= 1'b0;
        end else begin
            st_valid   <= in_valid;
            st_tgt     <= in_tgt;
            fwd_offset <= in_off;
            fwd_write  <= in_write;
            fwd_wdata  <= in_wdata;
            fwd_size   <= in_size;
            fwd_secure <= in_secure;
        end
    end

    // One-hot selects qualified by the stage valid.
    always_comb begin
        sel_sysreg = st_valid && (st_tgt == TGT_SYS);
        sel_tmr_s  = st_valid && (st_tgt == TGT_TMR_S);
        sel_tmr_ns = st_valid && (st_tgt == TGT_TMR_NS);
        sel_rel    = st_valid && (st_tgt == TGT_REL);
    end

    // Pick the read bus of the chosen slave; default responder gives zero.
    always_comb begin
        case (st_tgt)
            TGT_SYS:    slave_rd = rd_sysreg;
            TGT_TMR_S:  slave_rd = rd_tmr_s;
            TGT_TMR_NS: slave_rd = rd_tmr_ns;
            TGT_REL:    slave_rd = rd_rel;
            default:    slave_rd = '0;
        endcase
    end

    // Response fields: writes and idle cycles carry zero data.
    always_comb begin
        resp_valid = st_valid;
        resp_fault = st_valid && (st_tgt == TGT_FAULT);
        resp_rdata = (st_valid && !fwd_write) ? slave_rd : '0;
    end

    // R2
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(in_valid));

    // R1
    sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> !(sel_sysreg || sel_tmr_s || sel_tmr_ns || sel_rel || resp_fault));

    // R9
    fault_no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_fault |-> !(sel_sysreg || sel_tmr_s || sel_tmr_ns || sel_rel) && (resp_rdata == '0));
endmodule

// File: rtl/sys_space_router.sv
// Module: top of the system control space router. Decodes each request,
// registers the result for one cycle, and returns the response next cycle.
// Assumes a request can be taken every cycle (no back-pressure).
module sys_space_router
    import ppb_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter bit HAS_SEC = 1'b1,
    parameter bit HAS_REL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_priv,
    input  logic              req_secure,
    output logic              sel_sysreg,
    output logic              sel_tmr_s,
    output logic              sel_tmr_ns,
    output logic              sel_rel,
    output logic [PAGE_W-1:0] fwd_offset,
    output logic              fwd_write,
    output logic [DATA_W-1:0] fwd_wdata,
    output logic [1:0]        fwd_size,
    output logic              fwd_secure,
    input  logic [DATA_W-1:0] rd_sysreg,
    input  logic [DATA_W-1:0] rd_tmr_s,
    input  logic [DATA_W-1:0] rd_tmr_ns,
    input  logic [DATA_W-1:0] rd_rel,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              resp_fault
);
    ppb_tgt_e dec_tgt;
    logic     dec_secure;

    ppb_decode #(.ADDR_W(ADDR_W), .HAS_SEC(HAS_SEC), .HAS_REL(HAS_REL)) u_decode (
        .addr       (req_addr),
        .priv       (req_priv),
        .secure     (req_secure),
        .tgt        (dec_tgt),
        .eff_secure (dec_secure)
    );

    ppb_resp_stage #(.DATA_W(DATA_W), .OFF_W(PAGE_W)) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (req_valid),
        .in_tgt     (dec_tgt),
        .in_off     (req_addr[PAGE_W-1:0]),
        .in_write   (req_write),
        .in_wdata   (req_wdata),
        .in_size    (req_size),
        .in_secure  (dec_secure),
        .rd_sysreg  (rd_sysreg),
        .rd_tmr_s   (rd_tmr_s),
        .rd_tmr_ns  (rd_tmr_ns),
        .rd_rel     (rd_rel),
        .sel_sysreg (sel_sysreg),
        .sel_tmr_s  (sel_tmr_s),
        .sel_tmr_ns (sel_tmr_ns),
        .sel_rel    (sel_rel),
        .fwd_offset (fwd_offset),
        .fwd_write  (fwd_write),
        .fwd_wdata  (fwd_wdata),
        .fwd_size   (fwd_size),
        .fwd_secure (fwd_secure),
        .resp_valid (resp_valid),
        .resp_rdata (resp_rdata),
        .resp_fault (resp_fault)
    );

    // R5
    tmr_s_secure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_tmr_s |-> fwd_secure && !$past(req_addr[19:12] == PAGE_ALIAS));

    // R9
    fault_unpriv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_fault |-> !$past(req_priv));

    // R6
    alias_clears_secure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_sysreg || sel_tmr_ns) && $past(req_addr[19:12] == PAGE_ALIAS) |-> !fwd_secure);

    // R13
    write_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && fwd_write |-> resp_rdata == '0);
endmodule

// File: tb/sys_space_router_bench.sv
module sys_space_router_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [3:0]  sel;   // {rel, tmr_ns, tmr_s, sysreg}
        logic        fault;
        logic [31:0] rdata;
        logic        sec;
        logic [11:0] off;
        logic        wr;
        logic [31:0] wd;
        logic [1:0]  sz;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic req_write = 1'b0;
    logic [1:0] req_size = 2'd2;
    logic [31:0] req_wdata = '0;
    logic req_priv = 1'b1;
    logic req_secure = 1'b1;

    logic sa, ta, na, la, wa, sca, va, fa;
    logic [11:0] oa; logic [31:0] wda, rda; logic [1:0] sza;
    logic sb, tb_, nb, lb, wb, scb, vb, fb;
    logic [11:0] ob; logic [31:0] wdb, rdb; logic [1:0] szb;

    int checks = 0;
    int errors = 0;
    exp_t qa[$];
    exp_t qb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] stub(input logic [3:0] sel, input logic [11:0] off);
        case (sel)
            4'b0001: return 32'h5A00_0000 | {20'd0, off};
            4'b0010: return 32'h7500_0000 | {20'd0, off};
            4'b0100: return 32'h7A00_0000 | {20'd0, off};
            4'b1000: return 32'hAE00_0000 | {20'd0, off};
            default: return 32'h0;
        endcase
    endfunction

    // Slave stubs, tagged with identity and offset.
    logic [31:0] rs_a, rt_a, rn_a, rl_a, rs_b, rt_b, rn_b, rl_b;
    always_comb begin
        rs_a = stub(4'b0001, oa); rt_a = stub(4'b0010, oa);
        rn_a = stub(4'b0100, oa); rl_a = stub(4'b1000, oa);
        rs_b = stub(4'b0001, ob); rt_b = stub(4'b0010, ob);
        rn_b = stub(4'b0100, ob); rl_b = stub(4'b1000, ob);
    end

    sys_space_router u_sys_space_router (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_size(req_size), .req_wdata(req_wdata),
        .req_priv(req_priv), .req_secure(req_secure),
        .sel_sysreg(sa), .sel_tmr_s(ta), .sel_tmr_ns(na), .sel_rel(la),
        .fwd_offset(oa), .fwd_write(wa), .fwd_wdata(wda), .fwd_size(sza),
        .fwd_secure(sca), .rd_sysreg(rs_a), .rd_tmr_s(rt_a), .rd_tmr_ns(rn_a),
        .rd_rel(rl_a), .resp_valid(va), .resp_rdata(rda), .resp_fault(fa)
    );

    sys_space_router #(.HAS_SEC(1'b0), .HAS_REL(1'b0)) u_sys_space_router_bare (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_size(req_size), .req_wdata(req_wdata),
        .req_priv(req_priv), .req_secure(req_secure),
        .sel_sysreg(sb), .sel_tmr_s(tb_), .sel_tmr_ns(nb), .sel_rel(lb),
        .fwd_offset(ob), .fwd_write(wb), .fwd_wdata(wdb), .fwd_size(szb),
        .fwd_secure(scb), .rd_sysreg(rs_b), .rd_tmr_s(rt_b), .rd_tmr_ns(rn_b),
        .rd_rel(rl_b), .resp_valid(vb), .resp_rdata(rdb), .resp_fault(fb)
    );

    // Reference model built from the requirements.
    function automatic exp_t model(input logic [31:0] a, input logic wr, input logic pv,
                                   input logic sc, input logic [31:0] wd, input logic [1:0] sz,
                                   input bit has_sec, input bit has_rel, input string tag);
        exp_t e;
        logic in_sp;
        logic [7:0] pg;
        e.sel = 4'b0; e.fault = 1'b0; e.rdata = '0; e.sec = sc; e.off = a[11:0];
        e.wr = wr; e.wd = wd; e.sz = sz; e.tag = tag;
        in_sp = (a[31:20] == 12'hE00);
        pg = a[19:12];
        if (in_sp && has_rel && pg == 8'h05) e.sel = 4'b1000;
        else if (in_sp && (pg == 8'h0E || (has_sec && pg == 8'h2E && sc))) begin
            if (pg == 8'h2E) e.sec = 1'b0;
            if (a[11:0] >= 12'h010 && a[11:0] <= 12'h0EF) e.sel = e.sec ? 4'b0010 : 4'b0100;
            else e.sel = 4'b0001;
        end
        if (e.sel == 4'b0) e.fault = !pv;
        if (!wr) e.rdata = stub(e.sel, e.off);
        return e;
    endfunction

    task automatic compare(input string who, input exp_t e, input logic [3:0] sel, input logic flt,
                           input logic [31:0] rd, input logic sec, input logic [11:0] off,
                           input logic wr, input logic [31:0] wd, input logic [1:0] sz);
        checks++;
        if (sel !== e.sel || flt !== e.fault || rd !== e.rdata ||
            (e.sel != 4'b0 && {sec, off, wr, wd, sz} !== {e.sec, e.off, e.wr, e.wd, e.sz})) begin
            errors++;
            $display("FAIL %s %s: act sel=%b flt=%b rd=%h sec=%b off=%h wr=%b wd=%h sz=%0d exp sel=%b flt=%b rd=%h sec=%b off=%h wr=%b wd=%h sz=%0d",
                     e.tag, who, sel, flt, rd, sec, off, wr, wd, sz,
                     e.sel, e.fault, e.rdata, e.sec, e.off, e.wr, e.wd, e.sz);
        end
    endtask

    // Monitor: pops expected items as responses appear.
    always @(negedge clk) begin
        if (rst_n) begin
            if (va) begin
                if (qa.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R2 full: act resp_valid=1 exp resp_valid=0");
                end else compare("full", qa.pop_front(), {la, na, ta, sa}, fa, rda, sca, oa, wa, wda, sza);
            end
            if (vb) begin
                if (qb.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R2 bare: act resp_valid=1 exp resp_valid=0");
                end else compare("bare", qb.pop_front(), {lb, nb, tb_, sb}, fb, rdb, scb, ob, wb, wdb, szb);
            end
        end
    end

    // Driver: presents one request and queues its expected responses.
    task automatic drive(input logic [31:0] a, input logic wr, input logic pv, input logic sc,
                         input logic [1:0] sz, input string tag);
        logic [31:0] wd;
        wd = a ^ 32'h3C3C_5A5A;
        req_valid = 1'b1; req_addr = a; req_write = wr; req_priv = pv;
        req_secure = sc; req_size = sz; req_wdata = wd;
        qa.push_back(model(a, wr, pv, sc, wd, sz, 1'b1, 1'b1, tag));
        qb.push_back(model(a, wr, pv, sc, wd, sz, 1'b0, 1'b0, tag));
        @(negedge clk);
    endtask

    task automatic idle_check();
        req_valid = 1'b0;
        @(negedge clk);
        checks++;
        if (va !== 1'b0 || vb !== 1'b0) begin
            errors++;
            $display("FAIL R2 gap: act resp_valid=%b/%b exp 0/0", va, vb);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: act hung exp finished");
        summary();
        $finish;
    end

    initial begin
        // R1: request held during reset must not produce a response.
        req_valid = 1'b1; req_addr = 32'hE000_E000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if ({va, fa, sa, ta, na, la, vb, fb} !== 8'b0) begin
            errors++;
            $display("FAIL R1: act outputs=%b exp 0", {va, fa, sa, ta, na, la, vb, fb});
        end
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if ({va, fa, sa, ta, na, la} !== 6'b0) begin
            errors++;
            $display("FAIL R1 post: act outputs=%b exp 0", {va, fa, sa, ta, na, la});
        end

        drive(32'hE000_E000, 1'b0, 1'b1, 1'b1, 2'd2, "R3 base");
        drive(32'hE000_ED04, 1'b0, 1'b0, 1'b0, 2'd2, "R3 sysreg unpriv");
        drive(32'hE000_E00C, 1'b0, 1'b1, 1'b1, 2'd2, "R4 below timer");
        drive(32'hE000_E010, 1'b0, 1'b1, 1'b1, 2'd2, "R4 R5 timer low secure");
        drive(32'hE000_E010, 1'b0, 1'b1, 1'b0, 2'd2, "R5 timer nonsecure");
        drive(32'hE000_E0EF, 1'b0, 1'b1, 1'b0, 2'd0, "R4 timer top byte");
        drive(32'hE000_E0F0, 1'b0, 1'b1, 1'b0, 2'd2, "R4 above timer");
        idle_check();
        drive(32'hE000_ED00, 1'b1, 1'b1, 1'b1, 2'd2, "R13 sysreg write");
        drive(32'hE000_E018, 1'b1, 1'b1, 1'b0, 2'd1, "R13 timer write");
        drive(32'hE002_E010, 1'b0, 1'b1, 1'b1, 2'd2, "R6 alias timer");
        drive(32'hE002_ED00, 1'b0, 1'b1, 1'b1, 2'd2, "R6 alias sysreg");
        drive(32'hE002_E010, 1'b0, 1'b1, 1'b0, 2'd2, "R7 alias ns priv");
        drive(32'hE002_E400, 1'b0, 1'b0, 1'b0, 2'd2, "R7 alias ns unpriv");
        drive(32'hE002_E020, 1'b1, 1'b1, 1'b0, 2'd2, "R7 alias ns write");
        for (int s = 0; s < 4; s++) drive(32'hE000_1000, 1'b0, 1'b1, 1'b1, s[1:0], "R8 R12 unmapped sizes");
        drive(32'hE000_1004, 1'b1, 1'b1, 1'b0, 2'd3, "R8 unmapped write");
        drive(32'hE000_1000, 1'b0, 1'b0, 1'b1, 2'd2, "R9 unmapped unpriv");
        drive(32'hE00F_FFFC, 1'b0, 1'b0, 1'b0, 2'd2, "R9 top unpriv");
        drive(32'hE000_5010, 1'b0, 1'b1, 1'b1, 2'd2, "R10 R11 reliability");
        drive(32'hE000_5FFC, 1'b0, 1'b0, 1'b0, 2'd2, "R10 R11 reliability unpriv");
        drive(32'hE002_E004, 1'b0, 1'b0, 1'b1, 2'd2, "R11 alias removed");
        drive(32'hE010_0000, 1'b0, 1'b1, 1'b1, 2'd2, "R14 above space");
        drive(32'h2000_E010, 1'b0, 1'b0, 1'b1, 2'd2, "R14 outside unpriv");
        idle_check();
        repeat (2) @(negedge clk);
        checks++;
        if (qa.size() != 0 || qb.size() != 0) begin
            errors++;
            $display("FAIL R2 missing: act pending=%0d/%0d exp 0/0", qa.size(), qb.size());
        end
        summary();
        $finish;
    end
endmodule